// File: doc/BRIEF.md
# Multi-Mode Gated Photon Pulse Counter

This block counts photon pulses that arrive as short logic-level pulses on an external pin. It counts rising edges, not levels. A host processor sets it up by pushing a single command word over a one-way stream input. That word picks one of three counting modes and, for the periodic mode, a window length. Each measurement leaves as one result word on a second one-way stream output, which a downstream buffer of about 128 words absorbs. The block drives a write strobe and obeys the buffer's full flag.

Two external pins carry the measurement signals, and the mode decides what each pin means:

- **Gated mode:** pin A is the photon input and pin B is an active-high gate.
- **Periodic mode:** pin A is the photon input and pin B is unused.
- **Interval mode:** pin A is the start signal and pin B is the stop signal. The block measures the time from start to stop in system-clock cycles.

Both pins are asynchronous, so each is synchronized before its edges are detected.

If the output buffer is full when a result is ready, that result is discarded and a sticky overflow flag is raised. Counting carries on regardless.

Top module: `photon_gate_counter`

## Requirements
- R1: While rst_ni is low and after its release, res_write_o and ovf_o are 0 and the mode is idle.
- R2: cmd_read_o equals cmd_exists_i in the same cycle. A word is taken whenever cmd_exists_i is high. Bits [1:0] select the mode: 00 idle, 01 gated, 10 periodic, 11 interval. Bits [DATA_W-1:2] give the window length in cycles. Taking a word clears all counters, the interval arm and ovf_o, and any result due in that cycle is dropped.
- R3: Each pin passes two synchronizer flops and then an edge detector. A pin change driven between clock edges n-1 and n produces res_write_o high after edge n+2 when that change completes a measurement.
- R4: In gated mode, a pin A rising edge is counted only while the synchronized pin B is 1. A falling edge of pin B emits the accumulated count and restarts the count at 0.
- R5: In periodic mode with length P>0, a result is emitted every P cycles counted from command take. It holds the pin A edges seen in that window, including an edge in the window's last cycle. With P=0 no result is emitted.
- R6: In interval mode, a pin A rising edge arms the timer. A later pin B rising edge emits the number of cycles between the two edge detections and disarms the timer.
- R7: In interval mode, a pin B edge while disarmed is ignored. A second pin A edge while armed restarts the interval from that edge.
- R8: When pin A and pin B rise in the same cycle while armed, the current interval is emitted and the timer re-arms from that cycle.
- R9: A result word holds the mode code in its top two bits and the value in bits [DATA_W-3:0]. The value saturates at 2^(DATA_W-2)-1.
- R10: If res_full_i is high in the cycle a result becomes ready, the result is not written, ovf_o is set, and ovf_o stays set until the next command. No write is issued in a cycle following a full indication.
- R11: In idle mode no result is ever written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the interval time base |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_a_i | input | 1 | Photon pulse input, or start signal in interval mode |
| pin_b_i | input | 1 | Gate in gated mode, or stop signal in interval mode |
| cmd_data_i | input | DATA_W | Command word from the host stream |
| cmd_exists_i | input | 1 | Command stream has a word |
| cmd_read_o | output | 1 | Command word consumed this cycle |
| res_data_o | output | DATA_W | Result word (mode tag, value) |
| res_write_o | output | 1 | Result word valid, one-cycle strobe |
| res_full_i | input | 1 | Downstream result buffer full |
| ovf_o | output | 1 | Sticky flag: a result was lost to a full buffer |

## Verification
The critical coincidence is a stop edge and a start edge detected in the same cycle of interval mode. The closing of one interval and the arming of the next then compete for the timer. The bench provokes this directly by raising both pins at the same falling clock edge while the timer is armed. It expects the full elapsed count first and then a second interval measured from that shared cycle. A cycle-accurate reference model also meets this overlap in random start/stop traffic. The same model judges results that coincide with the full flag, which must be dropped and must set the overflow flag.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    M_IDLE = 2'b00,
    M_GATE = 2'b01,
    M_PER  = 2'b10,
    M_INTV = 2'b11
  } mode_e;
endpackage

// File: rtl/pc_edge.sv
module pc_edge #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign lvl_o[g]  = s2_q;
    assign rise_o[g] = s2_q & ~prev_q;
    assign fall_o[g] = ~s2_q & prev_q;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]); // R3
    AST_FALL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o[g] |=> !fall_o[g]); // R3
  end
endmodule

// File: rtl/pc_core.sv
module pc_core
  import pc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_take_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  input  logic              a_rise_i,
  input  logic              b_rise_i,
  input  logic              b_fall_i,
  input  logic              b_lvl_i,
  output mode_e             mode_o,
  output logic              emit_o,
  output logic [CNT_W-1:0]  val_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == MAX) ? v : v + ONE;
  endfunction

  mode_e            mode_q, mode_d;
  logic [CNT_W-1:0] per_q, per_d, cnt_q, cnt_d, tmr_q, tmr_d;
  logic             arm_q, arm_d;

  always_comb begin
    mode_d = mode_q;
    per_d  = per_q;
    cnt_d  = cnt_q;
    tmr_d  = tmr_q;
    arm_d  = arm_q;
    emit_o = 1'b0;
    val_o  = '0;
    if (cmd_take_i) begin
      mode_d = mode_e'(cmd_word_i[1:0]);
      per_d  = cmd_word_i[DATA_W-1:2];
      cnt_d  = '0;
      tmr_d  = '0;
      arm_d  = 1'b0;
    end else begin
      unique case (mode_q)
        M_GATE: begin
          if (b_fall_i) begin
            emit_o = 1'b1;
            val_o  = cnt_q;
            cnt_d  = '0;
          end else if (a_rise_i && b_lvl_i) begin
            cnt_d = sat_inc(cnt_q);
          end
        end
        M_PER: begin
          if (per_q != '0) begin
            if (a_rise_i) cnt_d = sat_inc(cnt_q);
            if (tmr_q == per_q - ONE) begin
              emit_o = 1'b1;
              val_o  = cnt_d;
              cnt_d  = '0;
              tmr_d  = '0;
            end else begin
              tmr_d = tmr_q + ONE;
            end
          end
        end
        M_INTV: begin
          if (arm_q) tmr_d = sat_inc(tmr_q);
          if (arm_q && b_rise_i) begin
            emit_o = 1'b1;
            val_o  = sat_inc(tmr_q);
            arm_d  = 1'b0;
          end
          // start wins over disarm: re-arm from this cycle
          if (a_rise_i) begin
            arm_d = 1'b1;
            tmr_d = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE;
      per_q  <= '0;
      cnt_q  <= '0;
      tmr_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      per_q  <= per_d;
      cnt_q  <= cnt_d;
      tmr_q  <= tmr_d;
      arm_q  <= arm_d;
    end
  end

  assign mode_o = mode_q;

  AST_STOP_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_INTV && !arm_q && b_rise_i && !cmd_take_i) |-> !emit_o); // R7
  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_INTV && a_rise_i && !cmd_take_i) |=> arm_q); // R8
endmodule

// File: rtl/pc_tx.sv
module pc_tx #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_take_i,
  input  logic              emit_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              full_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o   <= 1'b0;
      data_o <= '0;
      ovf_o  <= 1'b0;
    end else begin
      wr_o <= emit_i && !full_i;
      if (emit_i && !full_i) data_o <= word_i;
      if (cmd_take_i)                ovf_o <= 1'b0;
      else if (emit_i && full_i)     ovf_o <= 1'b1;
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !$past(full_i)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !cmd_take_i) |=> ovf_o); // R10
endmodule

// File: rtl/photon_gate_counter.sv
module photon_gate_counter
  import pc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              cmd_exists_i,
  output logic              cmd_read_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_write_o,
  input  logic              res_full_i,
  output logic              ovf_o
);
  localparam int CNT_W = DATA_W - 2;

  logic [1:0]       lvl, rise, fall;
  mode_e            mode;
  logic             emit;
  logic [CNT_W-1:0] val;

  assign cmd_read_o = cmd_exists_i;

  pc_edge #(.N(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({pin_b_i, pin_a_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  pc_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_take_i (cmd_exists_i),
    .cmd_word_i (cmd_data_i),
    .a_rise_i   (rise[0]),
    .b_rise_i   (rise[1]),
    .b_fall_i   (fall[1]),
    .b_lvl_i    (lvl[1]),
    .mode_o     (mode),
    .emit_o     (emit),
    .val_o      (val)
  );

  pc_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_take_i (cmd_exists_i),
    .emit_i     (emit),
    .word_i     ({mode, val}),
    .full_i     (res_full_i),
    .wr_o       (res_write_o),
    .data_o     (res_data_o),
    .ovf_o      (ovf_o)
  );

  AST_TAG_MATCHES_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_write_o |-> (res_data_o[DATA_W-1 -: 2] == $past(mode))); // R9
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == M_IDLE) |=> !res_write_o); // R11
endmodule

// File: tb/sim_photon_gate_counter.sv
module sim_photon_gate_counter;
  localparam int W  = 12;
  localparam int CW = W - 2;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, full = 1'b0, cmd_ex = 1'b0;
  logic [W-1:0] cmd_d = '0;
  logic cmd_rd, res_wr, ovf;
  logic [W-1:0] res_d;

  int n_chk = 0, n_bad = 0, n_res = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  photon_gate_counter #(.DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_a_i(pa), .pin_b_i(pb),
    .cmd_data_i(cmd_d), .cmd_exists_i(cmd_ex), .cmd_read_o(cmd_rd),
    .res_data_o(res_d), .res_write_o(res_wr), .res_full_i(full), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] sinc(input logic [CW-1:0] v);
    return (v == MAXV) ? v : v + 1'b1;
  endfunction

  // reference model, cycle accurate from the requirements
  logic [2:0] ha = '0, hb = '0;
  logic [1:0] m_mode = 2'b00;
  logic [CW-1:0] m_per = '0, m_cnt = '0, m_tmr = '0;
  logic m_arm = 1'b0, e_wr = 1'b0, e_ovf = 1'b0;
  logic [W-1:0] e_data = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ha <= '0; hb <= '0; m_mode <= 2'b00; m_per <= '0; m_cnt <= '0;
      m_tmr <= '0; m_arm <= 1'b0; e_wr <= 1'b0; e_ovf <= 1'b0; e_data <= '0;
    end else begin : step
      logic ar, br, bf, bl, em;
      logic [CW-1:0] v, c, t;
      logic a;
      ar = ha[1] & ~ha[2]; br = hb[1] & ~hb[2]; bf = ~hb[1] & hb[2]; bl = hb[1];
      em = 1'b0; v = '0; c = m_cnt; t = m_tmr; a = m_arm;
      if (cmd_ex) begin
        m_mode <= cmd_d[1:0]; m_per <= cmd_d[W-1:2];
        c = '0; t = '0; a = 1'b0;
      end else if (m_mode == 2'b01) begin
        if (bf) begin em = 1'b1; v = m_cnt; c = '0; end
        else if (ar && bl) c = sinc(m_cnt);
      end else if (m_mode == 2'b10 && m_per != '0) begin
        if (ar) c = sinc(m_cnt);
        if (m_tmr + 1'b1 == m_per) begin em = 1'b1; v = c; c = '0; t = '0; end
        else t = m_tmr + 1'b1;
      end else if (m_mode == 2'b11) begin
        if (m_arm) t = sinc(m_tmr);
        if (m_arm && br) begin em = 1'b1; v = sinc(m_tmr); a = 1'b0; end
        if (ar) begin a = 1'b1; t = '0; end
      end
      m_cnt <= c; m_tmr <= t; m_arm <= a;
      e_wr <= em && !full;
      if (em && !full) e_data <= {m_mode, v};
      if (cmd_ex) e_ovf <= 1'b0;
      else if (em && full) e_ovf <= 1'b1;
      ha <= {ha[1:0], pa};
      hb <= {hb[1:0], pb};
    end
  end

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b01: return "R4 gated result";
      2'b10: return "R5 periodic result";
      2'b11: return "R6 interval result";
      default: return "R11 idle result";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_wr || e_wr)
        chk(res_wr == e_wr && (!e_wr || res_d == e_data), tag_of(e_wr ? e_data[W-1:W-2] : res_d[W-1:W-2]),
            {19'd0, res_wr, res_d}, {19'd0, e_wr, e_data});
      if (ovf != e_ovf) chk(1'b0, "R10 overflow flag", ovf, e_ovf);
      if (res_wr) n_res++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] m, input int p);
    @(negedge clk);
    cmd_d = {p[CW-1:0], m};
    cmd_ex = 1'b1;
    #1 chk(cmd_rd == 1'b1, "R2 read strobe", cmd_rd, 1);
    @(negedge clk);
    cmd_ex = 1'b0;
    #1 chk(cmd_rd == 1'b0, "R2 read strobe low", cmd_rd, 0);
  endtask

  task automatic rnd(input int n, input int ra, input int rb, input int rf);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ($urandom % ra == 0) pa = ~pa;
      if ($urandom % rb == 0) pb = ~pb;
      full = (rf != 0) ? ($urandom % rf == 0) : 1'b0;
    end
    @(negedge clk);
    full = 1'b0;
  endtask

  // called at the negedge where the completing pin change is driven
  task automatic await_res(input int expv, input string req);
    int k = 0;
    while (!res_wr && k < 10) begin @(negedge clk); k++; end
    chk(res_wr && k == 3 && res_d[CW-1:0] == expv[CW-1:0], req, {22'd0, res_d[CW-1:0]}, expv);
    @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    tick(3);
    chk(res_wr == 1'b0 && ovf == 1'b0, "R1 reset outputs", {res_wr, ovf}, 0);
    rst_n = 1'b1;
    tick(3);
    chk(res_wr == 1'b0 && ovf == 1'b0, "R1 after reset", {res_wr, ovf}, 0);

    // R11 idle: pins active, nothing written
    base = n_res;
    rnd(300, 2, 3, 0);
    chk(n_res == base, "R11 idle writes", n_res - base, 0);

    // R4 gated directed: five pulses inside the gate
    send_cmd(2'b01, 0);
    pa = 1'b0; pb = 1'b1; tick(4);
    for (int i = 0; i < 5; i++) begin pa = 1'b1; tick(2); pa = 1'b0; tick(2); end
    pb = 1'b0;
    await_res(5, "R4 gated count");
    rnd(3000, 2, 25, 0);
    rnd(1500, 2, 20, 4);

    // R5 periodic
    send_cmd(2'b10, 0);
    base = n_res;
    rnd(300, 2, 5, 0);
    chk(n_res == base, "R5 zero period silent", n_res - base, 0);
    send_cmd(2'b10, 37);
    rnd(3000, 3, 7, 0);
    send_cmd(2'b10, 5);
    rnd(1500, 2, 7, 3);

    // R6..R8 interval directed
    send_cmd(2'b11, 0);
    pa = 1'b0; pb = 1'b0; tick(5);
    base = n_res;
    pb = 1'b1; tick(6); pb = 1'b0; tick(6);
    chk(n_res == base, "R7 stop without start", n_res - base, 0);
    pa = 1'b1; tick(3); pb = 1'b1;
    await_res(3, "R3 R6 interval latency");
    pa = 1'b0; pb = 1'b0; tick(3);
    pa = 1'b1; tick(5); pa = 1'b0; tick(3); pa = 1'b1; tick(4); pb = 1'b1;
    await_res(4, "R7 restart on second start");
    pa = 1'b0; pb = 1'b0; tick(3);
    pa = 1'b1; tick(6); pa = 1'b0; tick(4);
    pa = 1'b1; pb = 1'b1;
    await_res(10, "R8 coincident stop");
    pa = 1'b0; pb = 1'b0; tick(1); pb = 1'b1;
    await_res(5, "R8 rearmed interval");
    pa = 1'b0; pb = 1'b0; tick(3);
    pa = 1'b1; tick(1100); pb = 1'b1;
    await_res(int'(MAXV), "R9 saturation");
    chk(res_d[W-1:W-2] == 2'b11, "R9 mode tag", res_d[W-1:W-2], 3);

    // R10 overflow
    pa = 1'b0; pb = 1'b0; full = 1'b1; tick(3);
    base = n_res;
    pa = 1'b1; tick(4); pb = 1'b1; tick(6);
    chk(n_res == base, "R10 dropped when full", n_res - base, 0);
    chk(ovf == 1'b1, "R10 overflow set", ovf, 1);
    full = 1'b0; pa = 1'b0; pb = 1'b0; tick(3);
    pa = 1'b1; tick(2); pb = 1'b1;
    await_res(2, "R10 counting continues");
    chk(ovf == 1'b1, "R10 overflow sticky", ovf, 1);
    send_cmd(2'b11, 0);
    chk(ovf == 1'b0, "R2 command clears overflow", ovf, 0);
    rnd(4000, 30, 25, 0);
    rnd(2000, 20, 15, 5);

    send_cmd(2'b00, 0);
    base = n_res;
    rnd(200, 2, 2, 0);
    chk(n_res == base, "R11 idle again", n_res - base, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule